// File: doc/BRIEF.md
# Shared Queue Issue Priority Selector

The selector looks at every entry of a 32-slot instruction queue that all hardware threads share. Each cycle it picks up to six ready entries to send to the integer functional units. Thread identity plays no part in the choice. Each entry arrives with a ready bit, an age value, a memory-operation bit, and three qualifier flags. The branch flag marks a branch. The optimistic flag marks an instruction that was woken on the assumption that a load it depends on will hit. The speculative flag marks an instruction that sits behind an unresolved branch of its own thread. The logic that computes these flags lives outside the block.

A 2-bit policy input picks one preferred class: every entry, non-optimistic entries, non-speculative entries, or branches. The block ranks the preferred class ahead of all other entries, and the older entry wins inside each class. Only four of the six units can perform loads and stores, so no more than four memory operations are chosen per cycle. When that memory limit is hit, the free slots go to the next non-memory entries in priority order. The chosen set leaves the block as a registered grant vector with one bit per queue entry.

Top module: `iq_issue_sel`

## Requirements
- R1: While reset is asserted, and at the first clock edge after it is released, the grant vector is all zeros.
- R2: A grant bit is set only for an entry whose ready bit was high at the previous clock edge. Grants appear one clock after the inputs they were computed from.
- R3: No more than 6 grant bits are set in any cycle.
- R4: No more than 4 of the granted entries have their memory bit set.
- R5: With policy code 2'b00, ready entries are ranked purely by age. A larger age value means an older entry, and older entries rank first.
- R6: With policy code 2'b01, entries whose optimistic flag is set rank behind every ready entry whose flag is clear.
- R7: With policy code 2'b10, entries whose speculative flag is set rank behind every ready entry whose flag is clear.
- R8: With policy code 2'b11, ready entries whose branch flag is set rank ahead of every other entry.
- R9: Within one class, the larger age wins. When ages are equal, the lower entry index wins.
- R10: Entries are taken greedily in rank order. A memory entry is skipped once 4 memory grants are made, and later non-memory entries still fill the free slots. The number of grants equals min(6, non-memory ready + min(memory ready, 4)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Priority policy code (00 age, 01 optimistic last, 10 speculative last, 11 branch first) |
| rdy_i | input | 32 | Entry is ready to issue |
| mem_i | input | 32 | Entry is a load or store |
| br_i | input | 32 | Entry is a branch |
| opt_i | input | 32 | Entry was woken optimistically |
| spec_i | input | 32 | Entry is behind an unresolved same-thread branch |
| age_i | input | 192 | Six-bit age per entry, entry k at bits [6k+5:6k], larger is older |
| grant_o | output | 32 | Registered grant vector, one bit per entry |

## Verification
Every grant vector is due exactly one clock edge after the entry flags and policy that produced it. The bench sets inputs at a falling edge and works out the expected vector at once from its behavioural model. It then waits through one rising edge and compares the outputs at the following falling edge, before it applies the next set of inputs. Reset is checked the same way: the bench samples at a falling edge while reset is held, and again one edge after release with no ready entries.

// File: rtl/iq_sel_pkg.sv
package iq_sel_pkg;

  typedef enum logic [1:0] {
    POL_AGE       = 2'b00,
    POL_OPT_LAST  = 2'b01,
    POL_SPEC_LAST = 2'b10,
    POL_BR_FIRST  = 2'b11
  } policy_e;

endpackage

// File: rtl/iq_sel_key.sv
// Builds a per-entry priority key {preferred_class, age}; bigger key ranks first.
module iq_sel_key
  import iq_sel_pkg::*;
#(
  parameter int N     = 32,
  parameter int AGE_W = 6,
  parameter int KEY_W = AGE_W + 1
) (
  input  policy_e            policy_i,
  input  logic [N-1:0]       br_i,
  input  logic [N-1:0]       opt_i,
  input  logic [N-1:0]       spec_i,
  input  logic [N*AGE_W-1:0] age_i,
  output logic [N*KEY_W-1:0] key_o
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic pref;
    always_comb begin
      case (policy_i)
        POL_AGE:       pref = 1'b1;
        POL_OPT_LAST:  pref = ~opt_i[g];
        POL_SPEC_LAST: pref = ~spec_i[g];
        default:       pref = br_i[g];
      endcase
    end
    assign key_o[g*KEY_W +: KEY_W] = {pref, age_i[g*AGE_W +: AGE_W]};
  end

endmodule

// File: rtl/iq_sel_rank.sv
// For every entry, counts the ready entries that outrank it, split by memory bit.
module iq_sel_rank #(
  parameter int N     = 32,
  parameter int KEY_W = 7,
  parameter int CNT_W = 6
) (
  input  logic [N*KEY_W-1:0] key_i,
  input  logic [N-1:0]       rdy_i,
  input  logic [N-1:0]       mem_i,
  output logic [N*CNT_W-1:0] nm_before_o,
  output logic [N*CNT_W-1:0] mb_before_o
);

  for (genvar i = 0; i < N; i++) begin : g_row
    logic [N-1:0] beats;
    logic [KEY_W-1:0] ki;
    assign ki = key_i[i*KEY_W +: KEY_W];

    for (genvar j = 0; j < N; j++) begin : g_col
      logic [KEY_W-1:0] kj;
      assign kj = key_i[j*KEY_W +: KEY_W];
      if (j < i) begin : g_lo
        assign beats[j] = rdy_i[j] & (kj >= ki);
      end else if (j > i) begin : g_hi
        assign beats[j] = rdy_i[j] & (kj > ki);
      end else begin : g_self
        assign beats[j] = 1'b0;
      end
    end

    assign nm_before_o[i*CNT_W +: CNT_W] = CNT_W'($countones(beats & ~mem_i));
    assign mb_before_o[i*CNT_W +: CNT_W] = CNT_W'($countones(beats & mem_i));
  end

endmodule

// File: rtl/iq_sel_pick.sv
// Greedy take decision from the outranking counts: total slots and memory slots.
module iq_sel_pick #(
  parameter int N       = 32,
  parameter int CNT_W   = 6,
  parameter int ISSUE_W = 6,
  parameter int MEM_W   = 4
) (
  input  logic [N-1:0]       rdy_i,
  input  logic [N-1:0]       mem_i,
  input  logic [N*CNT_W-1:0] nm_before_i,
  input  logic [N*CNT_W-1:0] mb_before_i,
  output logic [N-1:0]       grant_o
);

  localparam int SUM_W = CNT_W + 1;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [CNT_W-1:0] nm_b, mb_b, mb_cap;
    logic [SUM_W-1:0] taken_before;
    logic             mem_room;

    assign nm_b         = nm_before_i[i*CNT_W +: CNT_W];
    assign mb_b         = mb_before_i[i*CNT_W +: CNT_W];
    assign mem_room     = (mb_b < CNT_W'(MEM_W));
    assign mb_cap       = mem_room ? mb_b : CNT_W'(MEM_W);
    assign taken_before = {1'b0, nm_b} + {1'b0, mb_cap};
    assign grant_o[i]   = rdy_i[i] & (taken_before < SUM_W'(ISSUE_W))
                        & (~mem_i[i] | mem_room);
  end

endmodule

// File: rtl/iq_issue_sel.sv
module iq_issue_sel
  import iq_sel_pkg::*;
#(
  parameter int N       = 32,
  parameter int AGE_W   = 6,
  parameter int ISSUE_W = 6,
  parameter int MEM_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         policy_i,
  input  logic [N-1:0]       rdy_i,
  input  logic [N-1:0]       mem_i,
  input  logic [N-1:0]       br_i,
  input  logic [N-1:0]       opt_i,
  input  logic [N-1:0]       spec_i,
  input  logic [N*AGE_W-1:0] age_i,
  output logic [N-1:0]       grant_o
);

  localparam int KEY_W = AGE_W + 1;
  localparam int CNT_W = $clog2(N + 1);

  logic [N*KEY_W-1:0] key;
  logic [N*CNT_W-1:0] nm_before, mb_before;
  logic [N-1:0]       grant_d, grant_q;
  logic               upd_en;

  iq_sel_key #(.N(N), .AGE_W(AGE_W), .KEY_W(KEY_W)) u_key (
    .policy_i (policy_e'(policy_i)),
    .br_i     (br_i),
    .opt_i    (opt_i),
    .spec_i   (spec_i),
    .age_i    (age_i),
    .key_o    (key)
  );

  iq_sel_rank #(.N(N), .KEY_W(KEY_W), .CNT_W(CNT_W)) u_rank (
    .key_i       (key),
    .rdy_i       (rdy_i),
    .mem_i       (mem_i),
    .nm_before_o (nm_before),
    .mb_before_o (mb_before)
  );

  iq_sel_pick #(.N(N), .CNT_W(CNT_W), .ISSUE_W(ISSUE_W), .MEM_W(MEM_W)) u_pick (
    .rdy_i       (rdy_i),
    .mem_i       (mem_i),
    .nm_before_i (nm_before),
    .mb_before_i (mb_before),
    .grant_o     (grant_d)
  );

  assign upd_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      grant_q <= '0;
    else if (upd_en) grant_q <= grant_d;
  end

  assign grant_o = grant_q;

  // ---------------- assertions ----------------
  logic             armed_q;
  logic [CNT_W-1:0] nm_rdy, m_rdy, m_cap, fill_c;
  logic [CNT_W:0]   fill_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign nm_rdy   = CNT_W'($countones(rdy_i & ~mem_i));
  assign m_rdy    = CNT_W'($countones(rdy_i & mem_i));
  assign m_cap    = (m_rdy > CNT_W'(MEM_W)) ? CNT_W'(MEM_W) : m_rdy;
  assign fill_sum = {1'b0, nm_rdy} + {1'b0, m_cap};
  assign fill_c   = (fill_sum > (CNT_W+1)'(ISSUE_W)) ? CNT_W'(ISSUE_W) : fill_sum[CNT_W-1:0];

  p_idle_in_reset_r1: assert property (@(posedge clk) !rst_n |=> grant_o == '0);

  p_ready_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (grant_o & ~$past(rdy_i)) == '0);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) <= ISSUE_W);

  p_mem_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o & $past(mem_i)) <= MEM_W || !armed_q);

  p_work_conserving_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> $countones(grant_o) == int'($past(fill_c)));

endmodule

// File: tb/tb_iq_issue_sel.sv
module tb_iq_issue_sel;
  localparam int CLK_P = 10;
  localparam int N     = 32;
  localparam int AGE_W = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       policy;
  logic [N-1:0]     rdy, mem, br, opt, spec;
  logic [N*AGE_W-1:0] age;
  logic [N-1:0]     grant;
  logic [N-1:0]     exp_g;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  iq_issue_sel dut (
    .clk(clk), .rst_n(rst_n), .policy_i(policy), .rdy_i(rdy), .mem_i(mem),
    .br_i(br), .opt_i(opt), .spec_i(spec), .age_i(age), .grant_o(grant)
  );

  function automatic int keyof(int i);
    int pref;
    case (policy)
      2'b00: pref = 1;
      2'b01: pref = opt[i] ? 0 : 1;
      2'b10: pref = spec[i] ? 0 : 1;
      default: pref = br[i] ? 1 : 0;
    endcase
    return pref * 1000 + int'(age[i*AGE_W +: AGE_W]);
  endfunction

  // behavioural model: repeatedly pull the best remaining ready entry
  task automatic model();
    bit used [N];
    int taken = 0;
    int mtaken = 0;
    exp_g = '0;
    for (int i = 0; i < N; i++) used[i] = 0;
    for (int k = 0; k < N; k++) begin
      int best = -1;
      for (int i = 0; i < N; i++)
        if (rdy[i] && !used[i] && (best < 0 || keyof(i) > keyof(best))) best = i;
      if (best < 0) break;
      used[best] = 1;
      if (taken < 6 && (!mem[best] || mtaken < 4)) begin
        exp_g[best] = 1'b1;
        taken++;
        if (mem[best]) mtaken++;
      end
    end
  endtask

  task automatic check(string req);
    total++;
    if (grant !== exp_g) begin
      bad++;
      $display("FAIL %s policy=%0d actual=%h expected=%h", req, policy, grant, exp_g);
    end
    total++;
    if ($countones(grant) > 6) begin
      bad++;
      $display("FAIL R3 actual=%0d expected<=6", $countones(grant));
    end
    total++;
    if ($countones(grant & mem) > 4) begin
      bad++;
      $display("FAIL R4 actual=%0d expected<=4", $countones(grant & mem));
    end
    total++;
    if ((grant & ~rdy) != '0) begin
      bad++;
      $display("FAIL R2 actual=%h expected=0", grant & ~rdy);
    end
  endtask

  // inputs already applied; wait one edge, compare at the falling edge
  task automatic step(string req);
    model();
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic clear_in();
    rdy = '0; mem = '0; br = '0; opt = '0; spec = '0; age = '0; policy = 2'b00;
  endtask

  function automatic string tag_of(logic [1:0] p);
    case (p)
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 1'b0;
    rdy = '1;
    repeat (3) @(negedge clk);
    total++;
    if (grant !== '0) begin bad++; $display("FAIL R1 actual=%h expected=0", grant); end
    rdy = '0;
    rst_n = 1'b1;
    step("R1");

    // R5: distinct ages, oldest first
    clear_in();
    rdy = '1;
    for (int i = 0; i < N; i++) age[i*AGE_W +: AGE_W] = AGE_W'((i * 7) % 64);
    step("R5");

    // R6: oldest entries optimistic, they fall behind
    policy = 2'b01;
    for (int i = 0; i < N; i++) opt[i] = (age[i*AGE_W +: AGE_W] > 6'd40);
    step("R6");

    // R7: speculative entries fall behind
    policy = 2'b10;
    opt = '0;
    spec = 32'h0F0F_F0F0;
    step("R7");

    // R8: young branches jump ahead
    policy = 2'b11;
    spec = '0;
    br = 32'h0000_0013;
    step("R8");

    // R9: equal ages, lower index wins
    clear_in();
    rdy = 32'hFFFF_0000;
    for (int i = 0; i < N; i++) age[i*AGE_W +: AGE_W] = 6'd9;
    step("R9");

    // R10 / R4: many old memory ops, young non-memory fill the remaining slots
    clear_in();
    for (int i = 0; i < 12; i++) begin
      rdy[i] = 1'b1; mem[i] = 1'b1; age[i*AGE_W +: AGE_W] = AGE_W'(50 + i);
    end
    for (int i = 20; i < 23; i++) begin
      rdy[i] = 1'b1; age[i*AGE_W +: AGE_W] = AGE_W'(i - 20);
    end
    step("R10");

    // R10: fewer candidates than slots
    clear_in();
    rdy = 32'h8000_0101;
    mem = 32'h0000_0101;
    step("R10");

    // random mix over all policies
    for (int n = 0; n < 3000; n++) begin
      policy = 2'($urandom_range(0, 3));
      rdy  = $urandom() & $urandom();
      if (n % 5 == 0) rdy = $urandom();
      mem  = $urandom();
      br   = $urandom() & $urandom();
      opt  = $urandom() & $urandom();
      spec = $urandom();
      for (int i = 0; i < N; i++)
        age[i*AGE_W +: AGE_W] = (n % 3 == 0) ? AGE_W'($urandom_range(0, 3))
                                             : AGE_W'($urandom());
      step(tag_of(policy));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule